// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block returns the downstream I2C segment to a known idle state before a new master is connected to it. A slave can be left mid-byte and holding SDA low. The block clears this by toggling SCL until the slave has shifted out its remaining bits. It then sends one more clock with SDA released, which reads as a not-acknowledge, and closes with a STOP condition.

The ownership controller starts a run with a single-cycle request. The request is accepted only while recovery is enabled and no run is in progress. Both bus lines are controlled as open-drain: each has a pull-low enable, and releasing a line lets the external pull-up raise it. The block never drives a line high.

A programmable count sets the length of each SCL phase, low or high, in core clock cycles. This lets the system choose any SCL rate up to 400 kHz. The bus SDA level is brought in through a two-stage synchronizer. When the sequence finishes, the block gives a one-cycle completion pulse, so the upstream master can be interrupted and the channel switch can proceed. Alongside the pulse it reports whether SDA was seen high at the end.

Top module: `busrec_seq`

## Requirements
- R1: After reset, and whenever no run is active, `scl_pull_low` and `sda_pull_low` are 0 and `busy` and `done` are 0.
- R2: When `start` is sampled high at a clock edge while `rec_enable` is 1 and `busy` is 0, `busy` becomes 1 after that edge and SCL is pulled low at once. This begins the first low phase.
- R3: Each run sends nine SCL pulses. Each pulse is one low phase and one released phase, and each phase lasts exactly H cycles. H is the latched half-period. SDA is released for the whole of these nine pulses.
- R4: A tenth SCL pulse with the same H-cycle timing follows the nine. SDA stays released during it, which forms the not-acknowledge.
- R5: The STOP uses three phases of H cycles each. First SDA and SCL are both pulled low. Next SCL is released while SDA stays low. Last both lines are released. While SCL is released, SDA changes only from pulled-low to released.
- R6: `done` is high for exactly one cycle, and `busy` is 0 in that same cycle. `done` comes 23·H cycles after the cycle in which `busy` first went high, and both lines are released at that point.
- R7: A `start` that arrives while `busy` is 1 has no effect on the running sequence or on its timing.
- R8: A `start` that arrives while `rec_enable` is 0 is ignored. `busy` stays 0 and both lines stay released.
- R9: `half_period` is latched when a request is accepted, and a `half_period` of 0 is treated as 1. Changes to it during a run do not affect that run.
- R10: In the cycle when `done` is high, `sda_clear` shows the synchronized SDA level taken at the end of the final phase, where 1 means released high. This is valid when H ≥ 3.
- R11: Driving `rst_n` low during a run aborts it. Both pull-low enables drop to 0 at once, and no `done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_enable | input | 1 | Recovery enabled; requests are ignored when 0 |
| start | input | 1 | Single-cycle request to run the recovery sequence |
| half_period | input | HP_W | SCL phase length in core cycles (0 acts as 1) |
| sda_in | input | 1 | Bus SDA level, asynchronous |
| scl_pull_low | output | 1 | Pull-low enable for SCL |
| sda_pull_low | output | 1 | Pull-low enable for SDA |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| sda_clear | output | 1 | SDA seen released at end of run, valid with `done` |

## Verification
The assertions check, on every cycle, that the lines are released while idle and that SDA never falls while SCL is released. They also check that an accepted request raises `busy` with SCL pulled low, and that `done` is a single cycle with `busy` low. Only the bench scenarios can show the exact length of each phase and the order of the 23 phases. The same holds for the pulse count, the effect of the latched half-period, the ignored requests, the SDA status at the end, and an abort by reset.

// File: rtl/busrec_pkg.sv
package busrec_pkg;
  localparam int unsigned CLK_PULSES = 10;            // nine recovery pulses plus NACK pulse
  localparam int unsigned STOP_PHASES = 3;
  localparam int unsigned NUM_PHASES = 2 * CLK_PULSES + STOP_PHASES;
  localparam int unsigned PH_W = $clog2(NUM_PHASES);

  typedef struct packed {
    logic scl_low;
    logic sda_low;
  } line_drv_t;

  // Drive pattern of each phase of the recovery sequence.
  function automatic line_drv_t phase_drive(input logic [PH_W-1:0] ph);
    line_drv_t d;
    d = '{scl_low: 1'b0, sda_low: 1'b0};
    if (ph < PH_W'(2 * CLK_PULSES)) begin
      d.scl_low = ~ph[0];
    end else if (ph == PH_W'(2 * CLK_PULSES)) begin
      d.scl_low = 1'b1;
      d.sda_low = 1'b1;
    end else if (ph == PH_W'(2 * CLK_PULSES + 1)) begin
      d.sda_low = 1'b1;
    end
    return d;
  endfunction
endpackage

// File: rtl/busrec_sync.sv
module busrec_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/busrec_tick.sv
module busrec_tick #(
  parameter int unsigned HP_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [HP_W-1:0] limit,
  output logic            tick
);
  logic [HP_W-1:0] cnt;

  assign tick = run && (cnt == limit - HP_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + HP_W'(1);
  end
endmodule

// File: rtl/busrec_fsm.sv
module busrec_fsm
  import busrec_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            rec_enable,
  input  logic            tick,
  input  logic            sda_sync,
  output logic            accept,
  output logic            busy,
  output logic            done,
  output logic            sda_clear,
  output logic [PH_W-1:0] phase
);
  localparam logic [PH_W-1:0] LAST = PH_W'(NUM_PHASES - 1);

  assign accept = start && rec_enable && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      sda_clear <= 1'b0;
      phase     <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy  <= 1'b1;
        phase <= '0;
      end else if (busy && tick) begin
        if (phase == LAST) begin
          busy      <= 1'b0;
          done      <= 1'b1;
          sda_clear <= sda_sync;
          phase     <= '0;
        end else begin
          phase <= phase + PH_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/busrec_seq.sv
module busrec_seq
  import busrec_pkg::*;
#(
  parameter int unsigned HP_W = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rec_enable,
  input  logic            start,
  input  logic [HP_W-1:0] half_period,
  input  logic            sda_in,
  output logic            scl_pull_low,
  output logic            sda_pull_low,
  output logic            busy,
  output logic            done,
  output logic            sda_clear
);
  logic            accept;
  logic            tick;
  logic            sda_sync;
  logic [PH_W-1:0] phase;
  logic [HP_W-1:0] hp_q;
  line_drv_t       drv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hp_q <= HP_W'(1);
    else if (accept) hp_q <= (half_period == '0) ? HP_W'(1) : half_period;
  end

  busrec_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(sda_in), .q_sync(sda_sync)
  );

  busrec_tick #(.HP_W(HP_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .limit(hp_q), .tick(tick)
  );

  busrec_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .rec_enable(rec_enable),
    .tick(tick), .sda_sync(sda_sync), .accept(accept), .busy(busy),
    .done(done), .sda_clear(sda_clear), .phase(phase)
  );

  assign drv          = busy ? phase_drive(phase) : '{scl_low: 1'b0, sda_low: 1'b0};
  assign scl_pull_low = drv.scl_low;
  assign sda_pull_low = drv.sda_low;
endmodule

// File: rtl/busrec_checker.sv
module busrec_checker (
  input logic clk,
  input logic rst_n,
  input logic rec_enable,
  input logic start,
  input logic scl_pull_low,
  input logic sda_pull_low,
  input logic busy,
  input logic done
);
  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_pull_low && !sda_pull_low));

  p_accept_pulls_scl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && rec_enable && !busy) |=> (busy && scl_pull_low));

  p_sda_no_fall_scl_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_pull_low && !$past(scl_pull_low) && (sda_pull_low != $past(sda_pull_low)))
      |-> !sda_pull_low);

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_not_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_disabled_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !rec_enable && !busy) |=> !busy);
endmodule

bind busrec_seq busrec_checker u_chk (
  .clk(clk), .rst_n(rst_n), .rec_enable(rec_enable), .start(start),
  .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low),
  .busy(busy), .done(done)
);

// File: tb/busrec_seq_bench.sv
module busrec_seq_bench;
  localparam int HP_W = 16;
  localparam int NPH  = 23;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            rec_enable = 1'b0;
  logic            start = 1'b0;
  logic [HP_W-1:0] half_period = '0;
  logic            slave_hold = 1'b0;
  logic            sda_in;
  logic            scl_pull_low, sda_pull_low, busy, done, sda_clear;
  int              n_chk = 0;
  int              n_fail = 0;

  always #2 clk = ~clk;   // 250 MHz
  assign sda_in = ~(sda_pull_low | slave_hold);

  busrec_seq #(.HP_W(HP_W)) u_busrec_seq (
    .clk(clk), .rst_n(rst_n), .rec_enable(rec_enable), .start(start),
    .half_period(half_period), .sda_in(sda_in), .scl_pull_low(scl_pull_low),
    .sda_pull_low(sda_pull_low), .busy(busy), .done(done), .sda_clear(sda_clear)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset lines", {scl_pull_low, sda_pull_low}, 0);
    check("R1 reset busy/done", {busy, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Full run with trace comparison; mid-run start pulse and half_period change.
  task automatic t_run(input int hp, input bit hold, input bit disturb);
    int he;
    int e3, e4, e5;
    he = (hp == 0) ? 1 : hp;
    e3 = 0; e4 = 0; e5 = 0;
    slave_hold = hold;
    rec_enable = 1'b1;
    half_period = HP_W'(hp);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R2 busy after accept", busy, 1);
    for (int c = 0; c < NPH * he; c++) begin
      int ph;
      bit es, ed;
      ph = c / he;
      es = (ph < 20) ? (ph % 2 == 0) : (ph == 20);
      ed = (ph == 20) || (ph == 21);
      if (scl_pull_low != es || sda_pull_low != ed || !busy || done) begin
        if (ph < 18) e3++;
        else if (ph < 20) e4++;
        else e5++;
      end
      if (disturb && c == 3) begin
        start = 1'b1;                      // R7: ignored while busy
        half_period = HP_W'(he + 5);       // R9: ignored until next accept
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check("R3 nine pulses, SDA released", e3, 0);
    check("R4 NACK pulse", e4, 0);
    check("R5 STOP phases", e5, 0);
    check("R6 done at 23*H", {done, busy}, 2'b10);
    check("R6 lines released at done", {scl_pull_low, sda_pull_low}, 0);
    if (he >= 3) check("R10 sda_clear", sda_clear, hold ? 0 : 1);
    @(negedge clk);
    check("R6 done single cycle", done, 0);
    if (disturb) check("R7 no second run from busy start", busy, 0);
    slave_hold = 1'b0;
  endtask

  task automatic t_disabled;
    rec_enable = 1'b0;
    half_period = HP_W'(2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 disabled start ignored busy", busy, 0);
    check("R8 disabled start lines", {scl_pull_low, sda_pull_low}, 0);
    rec_enable = 1'b1;
    @(negedge clk);
    check("R1 idle stays idle", busy, 0);
  endtask

  task automatic t_abort;
    bit saw_done;
    rec_enable = 1'b1;
    half_period = HP_W'(2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (41) @(negedge clk);   // inside STOP phase 20 (SDA and SCL low)
    check("R5 STOP low phase before abort", {scl_pull_low, sda_pull_low}, 2'b11);
    #1 rst_n = 1'b0;
    #0.5;
    check("R11 abort releases lines", {scl_pull_low, sda_pull_low}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    saw_done = 1'b0;
    repeat (60) begin
      @(negedge clk);
      if (done || busy) saw_done = 1'b1;
    end
    check("R11 no done after abort", saw_done, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_run(4, 1'b0, 1'b0);
        t_run(3, 1'b1, 1'b1);
        t_run(0, 1'b0, 1'b0);      // R9: zero acts as one
        t_run(5, 1'b0, 1'b1);
        t_disabled();
        t_abort();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule